// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front End

This block is the device-side serial front end of a 128-word by 16-bit three-wire (Microwire) EEPROM model. A fast system clock oversamples the chip-select, serial-clock and serial-data pins through a two-flop synchronizer, and serial-clock rising edges are detected in the system clock domain. Once chip select is high, the block waits for a start bit and shifts in a two-bit opcode and an eight-bit address field. It then decodes the instruction. For a read it drives the data output with one leading zero, then the addressed word MSB first. Words keep following with automatic address increment for as long as the serial clock runs.

The storage array sits inside the block. A separate write sequencer updates it through a single-word update port. That sequencer learns about each command from a one-cycle command strobe issued when chip select falls. The strobe carries the decoded instruction, the address, the last sixteen data bits shifted in and the number of serial-clock edges counted from the start bit. The sequencer uses the edge count to reject commands with too many or too few clocks. After chip select falls, it must stay low for a minimum deselect time before the next command. That rule belongs to the host and is not enforced here.

Top module: `mw_cmd_frontend`

## Requirements
- R1: While synchronized chip select is low, serial-clock and data inputs have no effect: no command strobe is produced, and `do_oe_o` is 0 from the cycle after chip select is seen low.
- R2: After chip select rises, serial-clock rising edges that sample data low are discarded. The first edge that samples data high is the start bit, and the edge count reported in the strobe starts at 1 on it.
- R3: The two bits after the start bit select the instruction: 10 read (code 1), 01 write (code 2), 11 erase (code 3). For 00, the next two bits select 11 enable (code 4), 00 disable (code 5), 01 fill-all (code 6) or 10 clear-all (code 7). A command ended before its selecting bits arrive reports code 0.
- R4: The eight-bit address field is sent MSB first. Its MSB is ignored and its low seven bits select the word.
- R5: For a read, from the 11th edge (address LSB) `do_oe_o` is 1 and `do_o` is 0. Each later edge presents the next data bit, bit 15 first.
- R6: After bit 0 of a word, the next edge presents bit 15 of the following address with no gap; address 127 is followed by address 0.
- R7: After reset every word reads as FFFFh.
- R8: When chip select falls after a start bit, `cmd_valid_o` pulses for exactly one cycle. With it come the instruction code, address bits [6:0], the last sixteen data bits received after the 11th edge (zero if none) and the edge count, which saturates at its maximum.
- R9: A word written through the update port (`upd_en_i`, `upd_addr_i`, `upd_data_i`) is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select pin |
| sk_i | input | 1 | Serial clock pin |
| di_i | input | 1 | Serial data in pin |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for do_o (0 = high impedance) |
| upd_en_i | input | 1 | Update-port write strobe from the write sequencer |
| upd_addr_i | input | 7 | Update-port word address |
| upd_data_i | input | 16 | Update-port word data |
| cmd_valid_o | output | 1 | One-cycle command strobe at chip-select fall |
| cmd_op_o | output | 3 | Decoded instruction code |
| cmd_addr_o | output | 7 | Address bits [6:0] of the command |
| cmd_data_o | output | 16 | Last sixteen data bits after the header |
| cmd_clks_o | output | 8 | Serial-clock edges counted from the start bit |

## Verification
A pin change reaches the block's outputs on the third system clock edge: two synchronizer flops, then the output register. Each data bit or output-enable change is therefore due three cycles after the serial-clock rise. The strobe is due three cycles after chip select falls. The bench changes pins on falling system clock edges, holds each serial-clock level for at least four cycles, and samples data out five cycles after each rise, while the value is stable. A falling-edge monitor latches the one-cycle strobe, and each command's strobe contents are checked six cycles after chip select falls.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_ERASE = 3'd3,
        OP_WREN  = 3'd4,
        OP_WRDIS = 3'd5,
        OP_FILL  = 3'd6,
        OP_CLEAR = 3'd7
    } mw_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_READ
    } mw_phase_e;

    function automatic mw_op_e mw_decode_main(input logic [1:0] code);
        case (code)
            2'b10:   return OP_READ;
            2'b01:   return OP_WRITE;
            2'b11:   return OP_ERASE;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic mw_op_e mw_decode_sub(input logic [1:0] code);
        case (code)
            2'b11:   return OP_WREN;
            2'b00:   return OP_WRDIS;
            2'b01:   return OP_FILL;
            default: return OP_CLEAR;
        endcase
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b0;
                sync_q[b] <= 1'b0;
            end else begin
                meta_q[b] <= d_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int unsigned WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mw_cmd_frontend.sv
module mw_cmd_frontend
    import mw_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    output logic              do_o,
    output logic              do_oe_o,
    input  logic              upd_en_i,
    input  logic [ADDR_W-1:0] upd_addr_i,
    input  logic [DATA_W-1:0] upd_data_i,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_op_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic [CNT_W-1:0]  cmd_clks_o
);
    localparam int unsigned ASR_W    = ADDR_W + 1;
    localparam int unsigned HDR_CLKS = 3 + ASR_W;
    localparam int unsigned IDX_W    = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        mw_phase_e         ph;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        opc;
        logic [ASR_W-1:0]  asr;
        logic [DATA_W-1:0] dsr;
        mw_op_e            op;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              dout;
        logic              oe;
        logic              vld;
        mw_op_e            vop;
        logic [ADDR_W-1:0] vaddr;
        logic [DATA_W-1:0] vdata;
        logic [CNT_W-1:0]  vclks;
        logic              sk_prev;
        logic              cs_prev;
    } fe_state_t;

    fe_state_t         s_d, s_q;
    logic [2:0]        pins_s;
    logic              cs_s, sk_s, di_s, sk_rise;
    logic [CNT_W-1:0]  cnt_n;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    mw_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sk_i, di_i}),
        .q_o   (pins_s)
    );

    assign cs_s    = pins_s[2];
    assign sk_s    = pins_s[1];
    assign di_s    = pins_s[0];
    assign sk_rise = sk_s & ~s_q.sk_prev;
    assign cnt_n   = (s_q.cnt == CNT_MAX) ? s_q.cnt : s_q.cnt + 1'b1;
    assign rd_addr = (s_q.ph == PH_READ) ? s_q.raddr + 1'b1
                                         : {s_q.asr[ADDR_W-2:0], di_s};

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (upd_en_i),
        .wr_addr_i (upd_addr_i),
        .wr_data_i (upd_data_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        s_d         = s_q;
        s_d.vld     = 1'b0;
        s_d.sk_prev = sk_s;
        s_d.cs_prev = cs_s;
        if (!cs_s) begin
            if (s_q.cs_prev && s_q.ph != PH_IDLE) begin
                s_d.vld   = 1'b1;
                s_d.vop   = s_q.op;
                s_d.vaddr = s_q.asr[ADDR_W-1:0];
                s_d.vdata = s_q.dsr;
                s_d.vclks = s_q.cnt;
            end
            s_d.ph   = PH_IDLE;
            s_d.cnt  = '0;
            s_d.opc  = '0;
            s_d.asr  = '0;
            s_d.dsr  = '0;
            s_d.op   = OP_NONE;
            s_d.idx  = IDX_TOP;
            s_d.oe   = 1'b0;
            s_d.dout = 1'b0;
        end else if (sk_rise) begin
            if (s_q.ph == PH_IDLE) begin
                if (di_s) begin
                    s_d.ph  = PH_HDR;
                    s_d.cnt = CNT_W'(1);
                end
            end else begin
                s_d.cnt = cnt_n;
                if (cnt_n <= CNT_W'(3))
                    s_d.opc = {s_q.opc[0], di_s};
                else if (cnt_n <= CNT_W'(HDR_CLKS))
                    s_d.asr = {s_q.asr[ASR_W-2:0], di_s};
                else
                    s_d.dsr = {s_q.dsr[DATA_W-2:0], di_s};

                if (cnt_n == CNT_W'(3) && {s_q.opc[0], di_s} != 2'b00)
                    s_d.op = mw_decode_main({s_q.opc[0], di_s});
                if (cnt_n == CNT_W'(5) && s_q.opc == 2'b00)
                    s_d.op = mw_decode_sub({s_q.asr[0], di_s});

                if (s_q.ph == PH_HDR && cnt_n == CNT_W'(HDR_CLKS) && s_q.op == OP_READ) begin
                    s_d.ph    = PH_READ;
                    s_d.raddr = rd_addr;
                    s_d.word  = rd_data;
                    s_d.idx   = IDX_TOP;
                    s_d.oe    = 1'b1;
                    s_d.dout  = 1'b0;
                end else if (s_q.ph == PH_READ) begin
                    s_d.dout = s_q.word[s_q.idx];
                    if (s_q.idx == '0) begin
                        s_d.raddr = rd_addr;
                        s_d.word  = rd_data;
                        s_d.idx   = IDX_TOP;
                    end else begin
                        s_d.idx = s_q.idx - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ph  <= PH_IDLE;
            s_q.op  <= OP_NONE;
            s_q.vop <= OP_NONE;
            s_q.idx <= IDX_TOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign do_o        = s_q.dout;
    assign do_oe_o     = s_q.oe;
    assign cmd_valid_o = s_q.vld;
    assign cmd_op_o    = s_q.vop;
    assign cmd_addr_o  = s_q.vaddr;
    assign cmd_data_o  = s_q.vdata;
    assign cmd_clks_o  = s_q.vclks;
endmodule

// File: rtl/mw_frontend_chk.sv
module mw_frontend_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             do_o,
    input logic             do_oe_o,
    input logic             cmd_valid_o,
    input logic [2:0]       cmd_op_o,
    input logic [CNT_W-1:0] cmd_clks_o
);
    // R1: synchronized chip select low forces the output into high impedance
    assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe_o);

    // R2: a strobe is only issued once a start bit has been counted
    assert_start_counted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_clks_o != '0);

    // R3: a decoded read needs at least the start bit and both opcode bits
    assert_read_needs_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == 3'd1) |-> cmd_clks_o >= CNT_W'(3));

    // R5: the first driven bit of a read is the leading zero
    assert_preamble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe_o) |-> !do_o);

    // R8: the command strobe lasts a single cycle
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
endmodule

bind mw_cmd_frontend mw_frontend_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .do_o        (do_o),
    .do_oe_o     (do_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_clks_o  (cmd_clks_o)
);

// File: tb/sim_mw_cmd_frontend.sv
module sim_mw_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic        do_o, do_oe_o;
    logic        upd_en = 1'b0;
    logic [6:0]  upd_addr = '0;
    logic [15:0] upd_data = '0;
    logic        cmd_valid_o;
    logic [2:0]  cmd_op_o;
    logic [6:0]  cmd_addr_o;
    logic [15:0] cmd_data_o;
    logic [7:0]  cmd_clks_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic        got;
    logic [2:0]  g_op;
    logic [6:0]  g_addr;
    logic [15:0] g_data;
    logic [7:0]  g_clks;
    logic        s_do, s_oe, any_oe;

    always #4 clk = ~clk;

    mw_cmd_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(do_o), .do_oe_o(do_oe_o),
        .upd_en_i(upd_en), .upd_addr_i(upd_addr), .upd_data_i(upd_data),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
        .cmd_data_o(cmd_data_o), .cmd_clks_o(cmd_clks_o)
    );

    always @(negedge clk) begin
        if (cmd_valid_o) begin
            got    <= 1'b1;
            g_op   <= cmd_op_o;
            g_addr <= cmd_addr_o;
            g_data <= cmd_data_o;
            g_clks <= cmd_clks_o;
        end
        if (do_oe_o) any_oe <= 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_edge(input logic d);
        @(negedge clk) di = d;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        repeat (5) @(negedge clk);
        s_do = do_o;
        s_oe = do_oe_o;
        sk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk);
        got = 1'b0;
        any_oe = 1'b0;
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) cs = 1'b0;
        di = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_edge(v[i]);
    endtask

    task automatic upd(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        upd_en = 1'b1; upd_addr = a; upd_data = d;
        @(negedge clk) upd_en = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic [2:0] op, input logic [6:0] a,
                              input logic [15:0] d, input logic [7:0] n);
        chk(got == 1'b1, req, 32'(got), 32'd1);
        chk(g_op == op, req, 32'(g_op), 32'(op));
        chk(g_addr == a, req, 32'(g_addr), 32'(a));
        chk(g_data == d, req, 32'(g_data), 32'(d));
        chk(g_clks == n, req, 32'(g_clks), 32'(n));
    endtask

    task automatic read_words(input int ndummy, input logic [7:0] afield,
                              input int nw, input logic [15:0] exp [4], input string req);
        logic [15:0] w;
        for (int i = 0; i < ndummy; i++) begin
            clk_edge(1'b0);
            chk(s_oe == 1'b0, "R2 dummy", 32'(s_oe), 32'd0);
        end
        send({53'd0, 1'b1, 2'b10, afield}, 11);
        chk(s_oe == 1'b1 && s_do == 1'b0, "R5 preamble", {s_oe, s_do}, 32'h2);
        for (int k = 0; k < nw; k++) begin
            for (int b = 15; b >= 0; b--) begin
                clk_edge(1'b0);
                w[b] = s_do;
            end
            chk(w == exp[k], req, 32'(w), 32'(exp[k]));
        end
    endtask

    task automatic t_reset();
        chk(do_oe_o == 1'b0, "R1 reset oe", 32'(do_oe_o), 32'd0);
        chk(cmd_valid_o == 1'b0, "R8 reset strobe", 32'(cmd_valid_o), 32'd0);
    endtask

    task automatic t_standby();
        got = 1'b0; any_oe = 1'b0;
        send(64'hFFF, 12);
        repeat (6) @(negedge clk);
        chk(got == 1'b0, "R1 standby strobe", 32'(got), 32'd0);
        chk(any_oe == 1'b0, "R1 standby oe", 32'(any_oe), 32'd0);
    endtask

    task automatic t_read_reset_word();
        logic [15:0] e [4];
        e = '{16'hFFFF, 16'hFFFF, 16'h0, 16'h0};
        cs_up();
        read_words(0, 8'h40, 2, e, "R7 erased word");
        cs_down();
        expect_cmd("R8 read strobe", 3'd1, 7'h40, 16'h0000, 8'd43);
    endtask

    task automatic t_read_seq();
        logic [15:0] e [4];
        upd(7'd5, 16'hA5C3);
        upd(7'd6, 16'h1234);
        e = '{16'hA5C3, 16'h1234, 16'h0, 16'h0};
        cs_up();
        read_words(3, 8'h05, 2, e, "R6 R9 sequential");
        cs_down();
        expect_cmd("R2 R8 count from start", 3'd1, 7'h05, 16'h0000, 8'd43);
        chk(do_oe_o == 1'b0, "R1 after read", 32'(do_oe_o), 32'd0);
    endtask

    task automatic t_read_wrap();
        logic [15:0] e [4];
        upd(7'd127, 16'hBEEF);
        upd(7'd0, 16'h0F0F);
        e = '{16'hBEEF, 16'h0F0F, 16'hFFFF, 16'h0};
        cs_up();
        read_words(0, 8'hFF, 3, e, "R4 R6 wrap");
        cs_down();
        expect_cmd("R4 R8 wrap strobe", 3'd1, 7'h7F, 16'h0000, 8'd59);
    endtask

    task automatic t_write_cmd();
        cs_up();
        send(64'b00, 2);
        send({37'd0, 1'b1, 2'b01, 8'h92, 16'hCAFE}, 27);
        cs_down();
        expect_cmd("R3 R4 write", 3'd2, 7'h12, 16'hCAFE, 8'd27);
        chk(any_oe == 1'b0, "R5 no drive on write", 32'(any_oe), 32'd0);
    endtask

    task automatic t_specials();
        cs_up(); send({53'd0, 1'b1, 2'b11, 8'h33}, 11); cs_down();
        expect_cmd("R3 erase", 3'd3, 7'h33, 16'h0, 8'd11);
        cs_up(); send({53'd0, 1'b1, 2'b00, 8'hC0}, 11); cs_down();
        expect_cmd("R3 enable", 3'd4, 7'h40, 16'h0, 8'd11);
        cs_up(); send({53'd0, 1'b1, 2'b00, 8'h00}, 11); cs_down();
        expect_cmd("R3 disable", 3'd5, 7'h00, 16'h0, 8'd11);
        cs_up(); send({37'd0, 1'b1, 2'b00, 8'h40, 16'h5A5A}, 27); cs_down();
        expect_cmd("R3 fill", 3'd6, 7'h40, 16'h5A5A, 8'd27);
        cs_up(); send({53'd0, 1'b1, 2'b00, 8'h80}, 11); cs_down();
        expect_cmd("R3 clear", 3'd7, 7'h00, 16'h0, 8'd11);
    endtask

    task automatic t_overcount_short();
        cs_up(); send({52'd0, 1'b1, 2'b11, 8'h01, 1'b1}, 12); cs_down();
        expect_cmd("R8 overcount", 3'd3, 7'h01, 16'h0001, 8'd12);
        cs_up(); send(64'b11, 2); cs_down();
        expect_cmd("R3 short", 3'd0, 7'h00, 16'h0, 8'd2);
    endtask

    task automatic t_abort_read();
        cs_up();
        send({53'd0, 1'b1, 2'b10, 8'h05}, 11);
        send(64'd0, 5);
        chk(s_oe == 1'b1, "R5 driving", 32'(s_oe), 32'd1);
        cs_down();
        chk(do_oe_o == 1'b0, "R1 abort", 32'(do_oe_o), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_standby();
        t_read_reset_word();
        t_read_seq();
        t_read_wrap();
        t_write_cmd();
        t_specials();
        t_overcount_short();
        t_abort_read();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule